// File: doc/BRIEF.md
# Channel-Group Power and Initialisation Controller

This block keeps one small control byte for each of fifteen channel groups. Every group carries two echo-cancelling channels, A and B, each with a tone detector. A host reaches the control bytes over a plain address/data bus. From each byte the block derives four things: whether the tone-detector interrupts of the two channels reach the outside, which PCM coding law and format the group's channels use, and whether the group is powered.

A group that is powered down sends its receive and send PCM samples straight through a short frame-clocked delay line. The output of the echo canceller is not used. When the power bit is raised, the group runs an initialisation that lasts a fixed number of frame strobes. During that time the block asks the group to preset its per-channel registers and to clear its adaptive-filter coefficients. It reports the group as busy until the sequence completes, and only then as active. Per-channel register writes are meant to be accepted only while the group reports active.

Top module: `grp_pwr_ctrl`

## Requirements
- R1: Fifteen control bytes sit at bus addresses 0x401 to 0x40F, group g at 0x401+g. All reset to 0x00. A write with wr_en lands on the next rising clock edge. With rd_en high, rdata returns the addressed byte in the same cycle. Any address outside that range reads 0x00, and a write to it changes no control byte and no output.
- R2: Bits 7:5 of every control byte always read back as 0, whatever value is written to them.
- R3: Bit 3 of a group's byte, when 1, forces irq_a_out of that group to 0. Bit 4 does the same for irq_b_out. When a mask bit is 0, the output follows tone_irq_a or tone_irq_b of that group.
- R4: law_sel of a group equals bit 1 of its byte (1 means A-law, 0 means µ-law). fmt_sel equals bit 2 (1 means G.711, 0 means sign-magnitude).
- R5: The write that sets bit 0 (power) of a byte from 0 to 1 raises busy and coef_clr of that group on the same edge. It also drives preset_req high for exactly the one following cycle. busy stays high through the first frame_stb after that write. On the edge of the second frame_stb, busy and coef_clr fall and active rises.
- R6: While the power bit of a group is 0, rout and sout of that group carry the rin and sin sample taken two frame strobes earlier. While the power bit is 1, they carry ec_rout and ec_sout of that group.
- R7: A write that clears the power bit during initialisation drops busy and coef_clr on that same edge. active stays 0 and the outputs return at once to the delayed path. A later power-up runs the full two-strobe sequence again.
- R8: Reset clears the delay lines, so a powered-down group outputs 0 on rout and sout until samples have been shifted in.
- R9: Writing a byte whose power bit is 1 to a group that is already active does not restart initialisation. busy and preset_req stay 0 and active stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read enable |
| addr | input | 12 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational |
| frame_stb | input | 1 | One-cycle pulse per PCM frame |
| tone_irq_a | input | 15 | Tone-detector interrupt of channel A, one bit per group |
| tone_irq_b | input | 15 | Tone-detector interrupt of channel B, one bit per group |
| irq_a_out | output | 15 | Channel A interrupt after masking |
| irq_b_out | output | 15 | Channel B interrupt after masking |
| law_sel | output | 15 | Companding law select per group |
| fmt_sel | output | 15 | PCM format select per group |
| busy | output | 15 | Initialisation in progress per group |
| active | output | 15 | Group powered and initialised |
| preset_req | output | 15 | One-cycle request to preset per-channel registers |
| coef_clr | output | 15 | Coefficient clear request, high while initialising |
| rin | input | 120 | Receive-in samples, 8 bits per group |
| sin | input | 120 | Send-in samples, 8 bits per group |
| ec_rout | input | 120 | Receive-out samples from the echo canceller |
| ec_sout | input | 120 | Send-out samples from the echo canceller |
| rout | output | 120 | Receive-out samples, 8 bits per group |
| sout | output | 120 | Send-out samples, 8 bits per group |

## Verification
The bench counts frame strobes after a power-up write. It checks that busy outlives the first strobe and gives way to active on the second. A counter off by one would either report active a frame early or hold busy a frame too long. It aborts a group halfway through initialisation and then powers it up again. A design that latched the half-finished count would go active after a single strobe, and one that ignored the abort would leave coef_clr asserted. It also feeds distinct samples through the powered-down path to confirm a delay of exactly two strobes. Further checks cover writes to addresses just outside the register range, writes with the unused top bits set, and rewrites of an already active group. Each of these would show up as a corrupted neighbour byte, stray upper bits in rdata, or a spurious second preset pulse.

// File: rtl/grp_pwr_pkg.sv
package grp_pwr_pkg;

    localparam int GRP_COUNT        = 15;
    localparam int PCM_BITS         = 8;
    localparam int BUS_AW           = 12;
    localparam int GRP_BASE         = 'h401;
    localparam int INIT_FRAMES_DEF  = 2;
    localparam int BYPASS_DEPTH_DEF = 2;
    localparam logic [7:0] CFG_USED_MASK = 8'h1F;

    // Control byte, MSB first: spare[7:5], mask_b[4], mask_a[3],
    // fmt_itu[2], law_a[1], pwr_on[0]
    typedef struct packed {
        logic [2:0] spare;
        logic       mask_b;
        logic       mask_a;
        logic       fmt_itu;
        logic       law_a;
        logic       pwr_on;
    } grp_cfg_t;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_INIT = 2'd1,
        GS_RUN  = 2'd2
    } grp_state_t;

    // Reduce a bus byte to the bits that are stored
    function automatic grp_cfg_t cfg_from_bus(input logic [7:0] v);
        return grp_cfg_t'(v & CFG_USED_MASK);
    endfunction

endpackage

// File: rtl/grp_regfile.sv
module grp_regfile
    import grp_pwr_pkg::*;
#(
    parameter int NUM_GRP   = GRP_COUNT,
    parameter int ADDR_W    = BUS_AW,
    parameter int BASE_ADDR = GRP_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output grp_cfg_t          cfg_q [NUM_GRP],
    output grp_cfg_t          cfg_d [NUM_GRP]
);

    logic [NUM_GRP-1:0] hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
        assign hit[g]   = (addr == ADDR_W'(BASE_ADDR + g));
        assign cfg_d[g] = (wr_en && hit[g]) ? cfg_from_bus(wdata) : cfg_q[g];

        always_ff @(posedge clk) begin
            if (rst) cfg_q[g] <= '0;
            else     cfg_q[g] <= cfg_d[g];
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_en && hit[g]) rdata = cfg_q[g];
        end
    end

endmodule

// File: rtl/grp_init_fsm.sv
module grp_init_fsm
    import grp_pwr_pkg::*;
#(
    parameter int INIT_FRAMES = INIT_FRAMES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_nxt,
    input  logic frame_stb,
    output logic busy,
    output logic active,
    output logic preset_pulse
);

    localparam int CNT_W = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);

    grp_state_t       st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= GS_OFF;
            cnt          <= '0;
            preset_pulse <= 1'b0;
        end else begin
            preset_pulse <= 1'b0;
            if (!pwr_nxt) begin
                st  <= GS_OFF;
                cnt <= '0;
            end else begin
                case (st)
                    GS_OFF: begin
                        st           <= GS_INIT;
                        cnt          <= '0;
                        preset_pulse <= 1'b1;
                    end
                    GS_INIT: begin
                        if (frame_stb) begin
                            if (cnt == LAST) st <= GS_RUN;
                            else             cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= GS_RUN;
                endcase
            end
        end
    end

    assign busy   = (st == GS_INIT);
    assign active = (st == GS_RUN);

endmodule

// File: rtl/grp_bypass_dly.sv
module grp_bypass_dly
    import grp_pwr_pkg::*;
#(
    parameter int PCM_W = PCM_BITS,
    parameter int DEPTH = BYPASS_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [PCM_W-1:0] din,
    output logic [PCM_W-1:0] dout
);

    logic [PCM_W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (stb) begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/grp_pwr_ctrl.sv
module grp_pwr_ctrl
    import grp_pwr_pkg::*;
#(
    parameter int NUM_GRP      = GRP_COUNT,
    parameter int PCM_W        = PCM_BITS,
    parameter int ADDR_W       = BUS_AW,
    parameter int BASE_ADDR    = GRP_BASE,
    parameter int INIT_FRAMES  = INIT_FRAMES_DEF,
    parameter int BYPASS_DEPTH = BYPASS_DEPTH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic                     frame_stb,
    input  logic [NUM_GRP-1:0]       tone_irq_a,
    input  logic [NUM_GRP-1:0]       tone_irq_b,
    output logic [NUM_GRP-1:0]       irq_a_out,
    output logic [NUM_GRP-1:0]       irq_b_out,
    output logic [NUM_GRP-1:0]       law_sel,
    output logic [NUM_GRP-1:0]       fmt_sel,
    output logic [NUM_GRP-1:0]       busy,
    output logic [NUM_GRP-1:0]       active,
    output logic [NUM_GRP-1:0]       preset_req,
    output logic [NUM_GRP-1:0]       coef_clr,
    input  logic [NUM_GRP*PCM_W-1:0] rin,
    input  logic [NUM_GRP*PCM_W-1:0] sin,
    input  logic [NUM_GRP*PCM_W-1:0] ec_rout,
    input  logic [NUM_GRP*PCM_W-1:0] ec_sout,
    output logic [NUM_GRP*PCM_W-1:0] rout,
    output logic [NUM_GRP*PCM_W-1:0] sout
);

    grp_cfg_t cfg_q [NUM_GRP];
    grp_cfg_t cfg_d [NUM_GRP];

    logic [NUM_GRP-1:0] pwr_v;
    logic [NUM_GRP-1:0] mask_a_v;
    logic [NUM_GRP-1:0] mask_b_v;

    grp_regfile #(
        .NUM_GRP  (NUM_GRP),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .cfg_q(cfg_q),
        .cfg_d(cfg_d)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [PCM_W-1:0] rx_dly;
        logic [PCM_W-1:0] tx_dly;

        assign pwr_v[g]    = cfg_q[g].pwr_on;
        assign mask_a_v[g] = cfg_q[g].mask_a;
        assign mask_b_v[g] = cfg_q[g].mask_b;
        assign law_sel[g]  = cfg_q[g].law_a;
        assign fmt_sel[g]  = cfg_q[g].fmt_itu;

        // Interrupt gating: detectors keep running, only the output is held
        assign irq_a_out[g] = tone_irq_a[g] & ~mask_a_v[g];
        assign irq_b_out[g] = tone_irq_b[g] & ~mask_b_v[g];

        grp_init_fsm #(
            .INIT_FRAMES(INIT_FRAMES)
        ) u_fsm (
            .clk         (clk),
            .rst         (rst),
            .pwr_nxt     (cfg_d[g].pwr_on),
            .frame_stb   (frame_stb),
            .busy        (busy[g]),
            .active      (active[g]),
            .preset_pulse(preset_req[g])
        );

        assign coef_clr[g] = busy[g];

        grp_bypass_dly #(
            .PCM_W(PCM_W),
            .DEPTH(BYPASS_DEPTH)
        ) u_rx_dly (
            .clk (clk),
            .rst (rst),
            .stb (frame_stb),
            .din (rin[g*PCM_W +: PCM_W]),
            .dout(rx_dly)
        );

        grp_bypass_dly #(
            .PCM_W(PCM_W),
            .DEPTH(BYPASS_DEPTH)
        ) u_tx_dly (
            .clk (clk),
            .rst (rst),
            .stb (frame_stb),
            .din (sin[g*PCM_W +: PCM_W]),
            .dout(tx_dly)
        );

        assign rout[g*PCM_W +: PCM_W] = pwr_v[g] ? ec_rout[g*PCM_W +: PCM_W] : rx_dly;
        assign sout[g*PCM_W +: PCM_W] = pwr_v[g] ? ec_sout[g*PCM_W +: PCM_W] : tx_dly;
    end

endmodule

// File: rtl/grp_pwr_ctrl_chk.sv
module grp_pwr_ctrl_chk #(
    parameter int NUM_GRP = 15,
    parameter int PCM_W   = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_en,
    input logic [7:0]               rdata,
    input logic                     frame_stb,
    input logic [NUM_GRP-1:0]       pwr_v,
    input logic [NUM_GRP-1:0]       mask_a_v,
    input logic [NUM_GRP-1:0]       mask_b_v,
    input logic [NUM_GRP-1:0]       irq_a_out,
    input logic [NUM_GRP-1:0]       irq_b_out,
    input logic [NUM_GRP-1:0]       busy,
    input logic [NUM_GRP-1:0]       active,
    input logic [NUM_GRP*PCM_W-1:0] rout
);

    p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rdata[7:5] == 3'b000));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        p_mask_a_r3: assert property (@(posedge clk) disable iff (rst)
            mask_a_v[g] |-> !irq_a_out[g]);

        p_mask_b_r3: assert property (@(posedge clk) disable iff (rst)
            mask_b_v[g] |-> !irq_b_out[g]);

        p_busy_excl_r5: assert property (@(posedge clk) disable iff (rst)
            !(busy[g] && active[g]));

        p_active_entry_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(active[g]) |-> ($past(frame_stb) && $past(busy[g])));

        p_off_idle_r7: assert property (@(posedge clk) disable iff (rst)
            !pwr_v[g] |-> (!busy[g] && !active[g]));

        p_bypass_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (!pwr_v[g] && !$past(pwr_v[g]) && !$past(frame_stb))
            |-> $stable(rout[g*PCM_W +: PCM_W]));
    end

endmodule

bind grp_pwr_ctrl grp_pwr_ctrl_chk #(
    .NUM_GRP(NUM_GRP),
    .PCM_W  (PCM_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .frame_stb(frame_stb),
    .pwr_v    (pwr_v),
    .mask_a_v (mask_a_v),
    .mask_b_v (mask_b_v),
    .irq_a_out(irq_a_out),
    .irq_b_out(irq_b_out),
    .busy     (busy),
    .active   (active),
    .rout     (rout)
);

// File: tb/grp_pwr_ctrl_bench.sv
module grp_pwr_ctrl_bench;

    localparam int NG = 15;
    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              frame_stb = 1'b0;
    logic [NG-1:0]     tone_irq_a = '1;
    logic [NG-1:0]     tone_irq_b = '1;
    logic [NG-1:0]     irq_a_out, irq_b_out, law_sel, fmt_sel;
    logic [NG-1:0]     busy, active, preset_req, coef_clr;
    logic [NG*PW-1:0]  rin = '0, sin = '0, ec_rout = '0, ec_sout = '0;
    logic [NG*PW-1:0]  rout, sout;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mr0 = 8'h00, mr1 = 8'h00;
    logic [7:0] ms0 = 8'h00, ms1 = 8'h00;

    always #2.5 clk = ~clk;

    grp_pwr_ctrl u_grp_pwr_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .frame_stb(frame_stb),
        .tone_irq_a(tone_irq_a), .tone_irq_b(tone_irq_b),
        .irq_a_out(irq_a_out), .irq_b_out(irq_b_out),
        .law_sel(law_sel), .fmt_sel(fmt_sel), .busy(busy), .active(active),
        .preset_req(preset_req), .coef_clr(coef_clr),
        .rin(rin), .sin(sin), .ec_rout(ec_rout), .ec_sout(ec_sout),
        .rout(rout), .sout(sout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    // Frame strobe with a requirement-level model of the two-stage delay
    task automatic strobe();
        @(negedge clk);
        frame_stb = 1'b1;
        mr1 = mr0; mr0 = rin[7:0];
        ms1 = ms0; ms0 = sin[7:0];
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    function automatic logic [7:0] grp_byte(input logic [NG*PW-1:0] v, input int g);
        return v[g*PW +: PW];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        for (int g = 0; g < NG; g++) begin
            bus_rd(12'h401 + 12'(g), d);
            chk("R1 reset byte", d, 0);
        end
        chk("R5 busy after reset", busy, 0);
        chk("R5 active after reset", active, 0);
        chk("R8 rout after reset", rout[31:0], 0);
        chk("R8 sout after reset", sout[31:0], 0);
        chk("R3 unmasked irq a", irq_a_out, 15'h7FFF);
        chk("R3 unmasked irq b", irq_b_out, 15'h7FFF);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_wr(12'h401, 8'hFE);
        bus_rd(12'h401, d);
        chk("R2 spare bits dropped g0", d, 8'h1E);
        bus_wr(12'h40F, 8'hEA);
        bus_rd(12'h40F, d);
        chk("R2 spare bits dropped g14", d, 8'h0A);
        bus_wr(12'h410, 8'hFF);
        bus_wr(12'h400, 8'hFF);
        bus_rd(12'h410, d);
        chk("R1 read above range", d, 0);
        bus_rd(12'h400, d);
        chk("R1 read below range", d, 0);
        bus_rd(12'h40F, d);
        chk("R1 g14 kept", d, 8'h0A);
        bus_rd(12'h402, d);
        chk("R1 g1 untouched", d, 0);
        chk("R1 no power side effect", busy | active, 0);
    endtask

    task automatic t_mask();
        chk("R3 irq a masked g0 g14", irq_a_out, 15'h3FFE);
        chk("R3 irq b masked g0", irq_b_out, 15'h7FFE);
        bus_wr(12'h401, 8'h08);
        chk("R3 irq b unmasked g0", irq_b_out, 15'h7FFF);
        chk("R3 irq a still masked", irq_a_out, 15'h3FFE);
        tone_irq_a = 15'h0001;
        #1 chk("R3 irq a follows input", irq_a_out, 15'h0000);
        tone_irq_a = '1;
    endtask

    task automatic t_codes();
        bus_wr(12'h404, 8'h04);
        chk("R4 law_sel", law_sel, 15'h4000);
        chk("R4 fmt_sel", fmt_sel, 15'h0008);
    endtask

    task automatic t_bypass();
        rin = {NG{8'h11}}; sin = {NG{8'hA1}};
        strobe();
        chk("R6 rout one strobe", grp_byte(rout, 5), 8'h00);
        rin = {NG{8'h22}}; sin = {NG{8'hA2}};
        strobe();
        chk("R6 rout two strobes", grp_byte(rout, 5), mr1);
        chk("R6 sout two strobes", grp_byte(sout, 5), ms1);
        rin = {NG{8'h33}}; sin = {NG{8'hA3}};
        strobe();
        chk("R6 rout next frame", grp_byte(rout, 5), 8'h22);
        ec_rout = {NG{8'hC5}}; ec_sout = {NG{8'h5C}};
        bus_wr(12'h406, 8'h01);
        chk("R6 powered rout from canceller", grp_byte(rout, 5), 8'hC5);
        chk("R6 powered sout from canceller", grp_byte(sout, 5), 8'h5C);
        bus_wr(12'h406, 8'h00);
        chk("R6 back to delayed rout", grp_byte(rout, 5), mr1);
        chk("R6 back to delayed sout", grp_byte(sout, 5), ms1);
    endtask

    task automatic t_powerup();
        bus_wr(12'h403, 8'h01);
        chk("R5 busy rises", busy, 15'h0004);
        chk("R5 preset pulse", preset_req, 15'h0004);
        chk("R5 coef clear", coef_clr, 15'h0004);
        @(negedge clk);
        chk("R5 preset one cycle", preset_req, 0);
        strobe();
        chk("R5 busy after first strobe", busy, 15'h0004);
        chk("R5 not active yet", active, 0);
        strobe();
        chk("R5 busy done", busy, 0);
        chk("R5 active", active, 15'h0004);
        chk("R5 coef clear done", coef_clr, 0);
    endtask

    task automatic t_rewrite();
        bus_wr(12'h403, 8'h19);
        chk("R9 no restart busy", busy, 0);
        chk("R9 no preset", preset_req, 0);
        chk("R9 still active", active, 15'h0004);
    endtask

    task automatic t_abort();
        bus_wr(12'h408, 8'h01);
        strobe();
        chk("R7 busy mid init", busy[7], 1);
        bus_wr(12'h408, 8'h00);
        chk("R7 busy dropped", busy[7], 0);
        chk("R7 coef clear dropped", coef_clr[7], 0);
        chk("R7 not active", active[7], 0);
        chk("R7 delayed path", grp_byte(rout, 7), mr1);
        bus_wr(12'h408, 8'h01);
        strobe();
        chk("R7 restart needs two strobes", busy[7], 1);
        strobe();
        chk("R7 active after restart", active[7], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_mask();
        t_codes();
        t_bypass();
        t_powerup();
        t_rewrite();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule